// File: doc/BRIEF.md
# Single-Wire Bus Master Controller

This block drives a single open-drain data line as bus master. A host issues two kinds of command through a small write/read register port. One is a bus reset, which checks whether any device answers. The other is a data transfer of one byte, or of one bit. Every bit is a time slot. The master pulls the line low for a short or a long time to send a 1 or a 0. It samples the line at a fixed point to read back what a device returns. Reading a byte means sending 0xFF and collecting the samples.

All slot and reset durations come from one cycle counter. Its compare limits are computed at elaboration from a clock-frequency parameter, in three sets: standard, standard with long-line stretch, and overdrive. A control register picks the set at run time. It also enables bit mode, presence masking and the active-low strong pull-up output. A forced-low line level can be held while idle. Completion flags are sticky and drive one interrupt output.

Top module: `ow_master`

## Requirements
- R1: After reset the line is released (`dq_oe`=0), `spu_n`=1, `irq`=0, and all flag and control bits read 0.
- R2: Writing 1 to command bit 0 runs a reset sequence. `dq_oe` is high for 480 µs at standard speed. The line is then released and sampled 70 µs later. The sequence ends 480 µs after release. Flag bit 1 (reset done) is then set, and flag bit 2 holds the sampled level (0 = device present).
- R3: Control bit 0 (overdrive) selects the fast set for every duration. Reset is 48 µs low, the presence sample is 8 µs after release, write-1 is 1 µs low, the sample is at 2 µs, write-0 is 7 µs low, the slot is 8 µs and recovery is 2 µs.
- R4: Writing 1 to command bit 1 transfers the data register LSB first. Each slot drives low for 60 µs on a 0 and 5 µs on a 1. It samples at 15 µs, lasts 65 µs and is followed by 7 µs of recovery. The eight samples, LSB first, are read back at address 1. Flag bit 0 (transfer done) is then set.
- R5: Control bit 6 (long line) at standard speed changes the write-1 low time to 8 µs, the sample point to 22 µs and recovery to 14 µs. It has no effect in overdrive.
- R6: With control bit 1 (bit mode) set, a transfer sends data bit 0 in one slot only. Address 1 then reads {7'b0, sampled bit}.
- R7: With control bit 3 set, `spu_n` is low during a command whenever the master neither drives the line nor waits for a sample point. `spu_n` is never low while `dq_oe` is high.
- R8: When idle, `spu_n` is low only if control bits 3 and 2 are both set. Bit 2 alone has no effect.
- R9: With control bit 5 (presence masking), the master drives the line low after release during reset. It starts 5 µs (1 µs overdrive) after release and stops at the presence sample point. Flag bit 2 then reads 0 even with no device.
- R10: When idle, command bit 2 (force low) drives `dq_oe` high only while control bit 4 is set.
- R11: Flag bits 0 and 1 stay set until the host writes 1 to them at address 2. `irq` is their OR. Flag bit 3 reads busy.
- R12: While busy, writes to addresses 0, 1 and 3 are ignored. Flag clears at address 2 still apply.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, frequency given by CLK_HZ |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 command, 1 data, 2 flags, 3 control |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address, same map |
| rd_data | output | 8 | Read data (combinational) |
| dq_in | input | 1 | Sensed level of the data line |
| dq_oe | output | 1 | 1 pulls the data line low |
| spu_n | output | 1 | Active-low strong pull-up enable |
| irq | output | 1 | Transfer-done or reset-done flag set |

## Verification
Several properties are checked on every cycle. The strong pull-up never overlaps a driven-low line. An idle pull-up needs its enable bit. A masked reset never reports absence. A bit-mode transfer ends after one slot. Control and data registers hold still under writes made while busy. The line is driven low at the sample instant of a write-0 slot. The bench scenarios cover exact pulse widths in each timing set and the LSB-first order. They also check the wired-AND read data against a modelled device, the sampled presence level, and whether commands issued mid-transfer are dropped.

// File: rtl/ow_pkg.sv
// Shared constants for the single-wire master: register addresses,
// control-bit positions, timing-phase indices and the sequencer state type.
// Assumes the clock frequency is a whole number of kHz.
package ow_pkg;

    localparam int NPH      = 9;
    localparam int PH_RSTL  = 0;   // reset low time
    localparam int PH_PS    = 1;   // presence sample, counted from release
    localparam int PH_PPM   = 2;   // masking pulse start, counted from release
    localparam int PH_RSTH  = 3;   // reset high time
    localparam int PH_W1    = 4;   // write-one / read low time
    localparam int PH_SMP   = 5;   // slot sample point
    localparam int PH_W0    = 6;   // write-zero low time
    localparam int PH_SLOT  = 7;   // slot length
    localparam int PH_REC   = 8;   // recovery after slot

    localparam logic [1:0] A_CMD  = 2'd0;
    localparam logic [1:0] A_DATA = 2'd1;
    localparam logic [1:0] A_FLAG = 2'd2;
    localparam logic [1:0] A_CTRL = 2'd3;

    localparam int C_OD  = 0;
    localparam int C_BIT = 1;
    localparam int C_SUP = 2;
    localparam int C_SPU = 3;
    localparam int C_FEN = 4;
    localparam int C_PPM = 5;
    localparam int C_LL  = 6;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RLOW,
        ST_RWAIT,
        ST_SLOT,
        ST_REC
    } seq_st_t;

    // Converts a duration in ns to whole clock cycles, rounding up.
    function automatic longint ns_to_cyc(longint hz, longint ns);
        return (hz / 64'sd1000 * ns + 64'sd999999) / 64'sd1000000;
    endfunction

endpackage

// File: rtl/ow_timing.sv
// Holds the per-phase cycle limits for the three timing sets and selects one
// set from the overdrive and long-line control bits. Long-line only changes
// the standard set. Assumes CW is wide enough for the longest limit.
module ow_timing
    import ow_pkg::*;
#(
    parameter longint CLK_HZ = 50_000_000,
    parameter int     CW     = 16
) (
    input  logic                     od,
    input  logic                     ll,
    output logic [NPH-1:0][CW-1:0]   tvec
);

    localparam longint STD_NS [NPH] = '{480000, 70000, 5000, 480000,
                                        5000, 15000, 60000, 65000, 7000};
    localparam longint LL_NS  [NPH] = '{480000, 70000, 5000, 480000,
                                        8000, 22000, 60000, 65000, 14000};
    localparam longint OD_NS  [NPH] = '{48000, 8000, 1000, 48000,
                                        1000, 2000, 7000, 8000, 2000};

    // One selector per phase: overdrive wins, then long line, else standard.
    for (genvar i = 0; i < NPH; i++) begin : g_ph
        localparam logic [CW-1:0] CS = CW'(ns_to_cyc(CLK_HZ, STD_NS[i]));
        localparam logic [CW-1:0] CL = CW'(ns_to_cyc(CLK_HZ, LL_NS[i]));
        localparam logic [CW-1:0] CO = CW'(ns_to_cyc(CLK_HZ, OD_NS[i]));
        assign tvec[i] = od ? CO : (ll ? CL : CS);
    end

endmodule

// File: rtl/ow_seq.sv
// Bus sequencer: runs reset/presence sequences and data slots with one
// cycle counter compared against the selected limits. Shifts LSB first,
// or moves a single bit in bit mode. Reports whether it is driving the line
// or waiting for a sample point. Assumes limits are stable while busy.
module ow_seq
    import ow_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start_rst,
    input  logic                   start_xfer,
    input  logic                   bit_mode,
    input  logic                   ppm_mode,
    input  logic [7:0]             tx_byte,
    input  logic [NPH-1:0][CW-1:0] tvec,
    input  logic                   dq_in,
    output logic                   busy,
    output logic                   drive,
    output logic                   waiting,
    output logic [7:0]             rx_byte,
    output logic                   xfer_done,
    output logic                   rst_done,
    output logic                   pres_bit
);

    seq_st_t        state;
    logic [CW-1:0]  cnt;
    logic [CW-1:0]  cnt_nx;
    logic [3:0]     left;
    logic           cur_bit;
    logic           mode_bit;
    logic           ppm_l;
    logic           pres_smp;
    logic [7:0]     sr;

    assign cnt_nx  = cnt + 1'b1;
    assign busy    = (state != ST_IDLE);
    assign rx_byte = sr;

    // Line drive and sample-wait windows decoded from state and counter.
    always_comb begin
        drive   = 1'b0;
        waiting = 1'b0;
        case (state)
            ST_RLOW:  drive = 1'b1;
            ST_RWAIT: begin
                drive   = ppm_l && (cnt >= tvec[PH_PPM]) && (cnt < tvec[PH_PS]);
                waiting = !drive && (cnt < tvec[PH_PS]);
            end
            ST_SLOT: begin
                drive   = cur_bit ? (cnt < tvec[PH_W1]) : (cnt < tvec[PH_W0]);
                waiting = cur_bit && (cnt >= tvec[PH_W1]) && (cnt < tvec[PH_SMP]);
            end
            default: ;
        endcase
    end

    // Phase sequencing, sampling, shifting and completion pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            cnt       <= '0;
            left      <= '0;
            cur_bit   <= 1'b0;
            mode_bit  <= 1'b0;
            ppm_l     <= 1'b0;
            pres_smp  <= 1'b1;
            pres_bit  <= 1'b0;
            sr        <= '0;
            xfer_done <= 1'b0;
            rst_done  <= 1'b0;
        end else begin
            xfer_done <= 1'b0;
            rst_done  <= 1'b0;
            case (state)
                ST_IDLE: begin
                    cnt <= '0;
                    if (start_rst) begin
                        state <= ST_RLOW;
                        ppm_l <= ppm_mode;
                    end else if (start_xfer) begin
                        state    <= ST_SLOT;
                        sr       <= tx_byte;
                        cur_bit  <= tx_byte[0];
                        mode_bit <= bit_mode;
                        left     <= bit_mode ? 4'd1 : 4'd8;
                    end
                end
                ST_RLOW: begin
                    cnt <= cnt_nx;
                    if (cnt_nx == tvec[PH_RSTL]) begin
                        cnt   <= '0;
                        state <= ST_RWAIT;
                    end
                end
                ST_RWAIT: begin
                    cnt <= cnt_nx;
                    if (cnt_nx == tvec[PH_PS]) begin
                        pres_smp <= dq_in;
                    end
                    if (cnt_nx == tvec[PH_RSTH]) begin
                        cnt      <= '0;
                        state    <= ST_IDLE;
                        rst_done <= 1'b1;
                        pres_bit <= ppm_l ? 1'b0 : pres_smp;
                    end
                end
                ST_SLOT: begin
                    cnt <= cnt_nx;
                    if (cnt_nx == tvec[PH_SMP]) begin
                        sr <= mode_bit ? {7'b0, dq_in} : {dq_in, sr[7:1]};
                    end
                    if (cnt_nx == tvec[PH_SLOT]) begin
                        cnt   <= '0;
                        state <= ST_REC;
                        left  <= left - 1'b1;
                    end
                end
                ST_REC: begin
                    cnt <= cnt_nx;
                    if (cnt_nx == tvec[PH_REC]) begin
                        cnt <= '0;
                        if (left == 4'd0) begin
                            state     <= ST_IDLE;
                            xfer_done <= 1'b1;
                        end else begin
                            state   <= ST_SLOT;
                            cur_bit <= sr[0];
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R9: a masked reset never reports an absent device.
    p_mask_present_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rst_done |-> !(ppm_l && pres_bit));

    // R6: in bit mode the first recovery is the last one.
    p_bitmode_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_REC && mode_bit) |-> (left == 4'd0));

    // R4: a write-zero slot still holds the line at its sample instant.
    p_w0_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SLOT && !cur_bit && cnt_nx == tvec[PH_SMP]) |-> drive);

    // R4: the slot counter stays inside the slot length.
    p_slot_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SLOT) |-> (cnt < tvec[PH_SLOT]));

endmodule

// File: rtl/ow_regs.sv
// Host register file: command, data, sticky flags and control. Produces
// start pulses for the sequencer. Ignores command, data and control writes
// while the sequencer is busy. Flags are write-one-to-clear, and a set
// arriving in the same cycle wins over the clear.
module ow_regs
    import ow_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [1:0] wr_addr,
    input  logic [7:0] wr_data,
    input  logic [1:0] rd_addr,
    output logic [7:0] rd_data,
    input  logic       busy,
    input  logic [7:0] rx_byte,
    input  logic       pres_bit,
    input  logic       xfer_done,
    input  logic       rst_done,
    output logic [6:0] ctrl,
    output logic       force_bit,
    output logic [7:0] tx_byte,
    output logic       start_rst,
    output logic       start_xfer,
    output logic       irq
);

    logic done_f;
    logic rdone_f;
    logic wr_ok;
    logic clr_wr;

    assign wr_ok      = wr_en && !busy;
    assign clr_wr     = wr_en && (wr_addr == A_FLAG);
    assign start_rst  = wr_ok && (wr_addr == A_CMD) && wr_data[0];
    assign start_xfer = wr_ok && (wr_addr == A_CMD) && wr_data[1] && !wr_data[0];
    assign irq        = done_f || rdone_f;

    // Configuration, data and force-level storage, written only when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl      <= '0;
            tx_byte   <= '0;
            force_bit <= 1'b0;
        end else if (wr_ok) begin
            case (wr_addr)
                A_CMD:   force_bit <= wr_data[2];
                A_DATA:  tx_byte   <= wr_data;
                A_CTRL:  ctrl      <= wr_data[6:0];
                default: ;
            endcase
        end
    end

    // Sticky completion flags with write-one-to-clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_f  <= 1'b0;
            rdone_f <= 1'b0;
        end else begin
            if (xfer_done)                   done_f  <= 1'b1;
            else if (clr_wr && wr_data[0])   done_f  <= 1'b0;
            if (rst_done)                    rdone_f <= 1'b1;
            else if (clr_wr && wr_data[1])   rdone_f <= 1'b0;
        end
    end

    // Read-back multiplexer.
    always_comb begin
        case (rd_addr)
            A_CMD:   rd_data = {5'b0, force_bit, 2'b0};
            A_DATA:  rd_data = rx_byte;
            A_FLAG:  rd_data = {4'b0, busy, pres_bit, rdone_f, done_f};
            default: rd_data = {1'b0, ctrl};
        endcase
    end

    // R12: control does not move on a write made while busy.
    p_ctrl_locked_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_en && wr_addr == A_CTRL) |=> $stable(ctrl));

    // R12: the data register does not move on a write made while busy.
    p_data_locked_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_en && wr_addr == A_DATA) |=> $stable(tx_byte));

    // R11: a done flag only falls on a host clear.
    p_done_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (done_f && !(clr_wr && wr_data[0])) |=> done_f);

endmodule

// File: rtl/ow_master.sv
// Top of the single-wire master. Ties the register file, timing selector
// and sequencer together. Produces the line enable, including the idle
// force-low level, and the active-low strong pull-up. Assumes an external
// pull-up resistor on the line and that dq_in is already synchronised.
module ow_master
    import ow_pkg::*;
#(
    parameter longint CLK_HZ = 50_000_000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [1:0] wr_addr,
    input  logic [7:0] wr_data,
    input  logic [1:0] rd_addr,
    output logic [7:0] rd_data,
    input  logic       dq_in,
    output logic       dq_oe,
    output logic       spu_n,
    output logic       irq
);

    localparam int CW = $clog2(ns_to_cyc(CLK_HZ, 480000) + 1);

    logic [6:0]             ctrl;
    logic                   force_bit;
    logic [7:0]             tx_byte;
    logic                   start_rst;
    logic                   start_xfer;
    logic                   busy;
    logic                   drive;
    logic                   waiting;
    logic [7:0]             rx_byte;
    logic                   xfer_done;
    logic                   rst_done;
    logic                   pres_bit;
    logic [NPH-1:0][CW-1:0] tvec;
    logic                   force_low;

    ow_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .rd_addr    (rd_addr),
        .rd_data    (rd_data),
        .busy       (busy),
        .rx_byte    (rx_byte),
        .pres_bit   (pres_bit),
        .xfer_done  (xfer_done),
        .rst_done   (rst_done),
        .ctrl       (ctrl),
        .force_bit  (force_bit),
        .tx_byte    (tx_byte),
        .start_rst  (start_rst),
        .start_xfer (start_xfer),
        .irq        (irq)
    );

    ow_timing #(.CLK_HZ(CLK_HZ), .CW(CW)) u_timing (
        .od   (ctrl[C_OD]),
        .ll   (ctrl[C_LL]),
        .tvec (tvec)
    );

    ow_seq #(.CW(CW)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_rst  (start_rst),
        .start_xfer (start_xfer),
        .bit_mode   (ctrl[C_BIT]),
        .ppm_mode   (ctrl[C_PPM]),
        .tx_byte    (tx_byte),
        .tvec       (tvec),
        .dq_in      (dq_in),
        .busy       (busy),
        .drive      (drive),
        .waiting    (waiting),
        .rx_byte    (rx_byte),
        .xfer_done  (xfer_done),
        .rst_done   (rst_done),
        .pres_bit   (pres_bit)
    );

    // Line enable: sequencer drive, or the gated force-low level when idle.
    assign force_low = !busy && ctrl[C_FEN] && force_bit;
    assign dq_oe     = drive || force_low;

    // Strong pull-up: during a command outside drive/sample-wait windows,
    // when idle only with the supply bit, and always gated by the enable.
    always_comb begin
        if (busy) spu_n = !(ctrl[C_SPU] && !drive && !waiting);
        else      spu_n = !(ctrl[C_SPU] && ctrl[C_SUP] && !force_low);
    end

    // R7: the strong pull-up never fights a driven-low line.
    p_spu_vs_drive_r7: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> spu_n);

    // R8: when idle, the pull-up needs its enable bit.
    p_idle_supply_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !ctrl[C_SPU]) |-> spu_n);

endmodule

// File: tb/sim_ow_master.sv
`timescale 1ns/1ps
module sim_ow_master;

    localparam longint HZ = 4_000_000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [1:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       dq_oe;
    logic       spu_n;
    logic       irq;
    logic       slave_low = 1'b0;
    wire        dq_in = !(dq_oe || slave_low);

    int  n_chk = 0;
    int  n_bad = 0;
    int  widths [16];
    int  nw = 0;
    int  cur = 0;
    bit  exp_reset = 1'b0;
    bit  present = 1'b1;
    bit  m_od = 1'b0;
    bit  m_ll = 1'b0;
    logic [7:0] slave_byte = 8'hFF;
    int  sbit = 0;

    always #2.5 clk = ~clk;

    ow_master #(.CLK_HZ(HZ)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .dq_in(dq_in), .dq_oe(dq_oe), .spu_n(spu_n), .irq(irq)
    );

    // Expected durations in cycles, from the requirement tables.
    function automatic int cyc(int ns);
        return (ns * 4 + 999) / 1000;
    endfunction
    function automatic int e_rstl(bit od); return od ? cyc(48000) : cyc(480000); endfunction
    function automatic int e_ps(bit od);   return od ? cyc(8000)  : cyc(70000);  endfunction
    function automatic int e_ppm(bit od);  return od ? cyc(1000)  : cyc(5000);   endfunction
    function automatic int e_w0(bit od);   return od ? cyc(7000)  : cyc(60000);  endfunction
    function automatic int e_w1(bit od, bit ll);
        return od ? cyc(1000) : (ll ? cyc(8000) : cyc(5000));
    endfunction
    function automatic int e_smp(bit od, bit ll);
        return od ? cyc(2000) : (ll ? cyc(22000) : cyc(15000));
    endfunction

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        rd_addr = a;
        #0.5 d = rd_data;
    endtask

    task automatic wait_flag(int bitpos);
        logic [7:0] f;
        for (int i = 0; i < 12000; i++) begin
            rd(2'd2, f);
            if (f[bitpos]) return;
        end
    endtask

    // Low-pulse width monitor on the line enable.
    initial begin
        forever begin
            @(negedge clk);
            if (dq_oe) cur++;
            else if (cur != 0) begin
                if (nw < 16) widths[nw] = cur;
                nw++;
                cur = 0;
            end
        end
    end

    // Device model: presence after a reset, pulls low for zero bits in slots.
    initial begin
        forever begin
            @(negedge dq_oe);
            if (exp_reset) begin
                if (present) begin
                    repeat (e_ps(m_od) / 2) @(posedge clk);
                    slave_low = 1'b1;
                    repeat (e_ps(m_od)) @(posedge clk);
                    slave_low = 1'b0;
                end
            end else begin
                if (!slave_byte[sbit % 8]) begin
                    slave_low = 1'b1;
                    repeat (e_smp(m_od, m_ll) - e_w1(m_od, m_ll) + 2) @(posedge clk);
                    slave_low = 1'b0;
                end
                sbit++;
            end
        end
    end

    task automatic do_reset(bit od, bit ppm, bit pres, bit exp_pres, string tag);
        logic [7:0] f;
        m_od = od; present = pres; exp_reset = 1'b1; nw = 0;
        wr(2'd3, {2'b0, ppm, 4'b0, od});
        wr(2'd0, 8'h01);
        wait_flag(1);
        rd(2'd2, f);
        chk({tag, " R2 presence bit"}, f[2], exp_pres);
        chk({tag, " R11 irq on reset done"}, irq, 1);
        chk({tag, " R2/R3 reset low width"}, widths[0], e_rstl(od));
        if (ppm) chk({tag, " R9 masking pulse width"}, widths[1], e_ps(od) - e_ppm(od));
        exp_reset = 1'b0;
        wr(2'd2, 8'h02);
        chk({tag, " R11 irq after clear"}, irq, 0);
    endtask

    task automatic begin_xfer(bit od, bit ll, bit bm, logic [7:0] tx, logic [7:0] sb);
        m_od = od; m_ll = ll; slave_byte = sb; sbit = 0; nw = 0;
        wr(2'd3, {1'b0, ll, 4'b0, bm, od});
        wr(2'd1, tx);
        wr(2'd0, 8'h02);
    endtask

    task automatic end_xfer(bit od, bit ll, bit bm, logic [7:0] tx, logic [7:0] sb, string tag);
        logic [7:0] d;
        logic [7:0] f;
        int nb;
        wait_flag(0);
        rd(2'd1, d);
        nb = bm ? 1 : 8;
        if (bm) chk({tag, " R6 bit-mode rx"}, d, {7'b0, tx[0] & sb[0]});
        else    chk({tag, " R4 byte rx"}, d, tx & sb);
        chk({tag, " R4/R6 slot count"}, nw, nb);
        for (int i = 0; i < nb; i++)
            chk({tag, " R3/R4/R5 slot low width"}, widths[i],
                tx[i] ? e_w1(od, ll) : e_w0(od));
        rd(2'd2, f);
        chk({tag, " R11 done flag"}, f[0], 1);
        wr(2'd2, 8'h01);
        rd(2'd2, f);
        chk({tag, " R11 done cleared"}, f[0], 0);
    endtask

    task automatic do_xfer(bit od, bit ll, bit bm, logic [7:0] tx, logic [7:0] sb, string tag);
        begin_xfer(od, ll, bm, tx, sb);
        end_xfer(od, ll, bm, tx, sb, tag);
    endtask

    // Watchdog: a hang counts as a failure and still reports.
    initial begin
        #(5.0 * 190000);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] d;
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 dq_oe", dq_oe, 0);
        chk("R1 spu_n", spu_n, 1);
        chk("R1 irq", irq, 0);
        rd(2'd2, d); chk("R1 flags", d, 0);
        rd(2'd3, d); chk("R1 ctrl", d, 0);

        do_reset(0, 0, 1, 0, "std present");
        do_reset(0, 0, 0, 1, "std absent");
        do_reset(1, 0, 1, 0, "od present");
        do_reset(1, 1, 0, 0, "od masked absent");

        do_xfer(0, 0, 0, 8'hA5, 8'h3C, "std byte");
        do_xfer(0, 1, 0, 8'hFF, 8'h96, "std longline read");
        do_xfer(1, 1, 0, 8'h6B, 8'hFF, "od longline ignored R5");
        do_xfer(1, 0, 1, 8'hFF, 8'hFE, "od bit zero");
        do_xfer(0, 0, 1, 8'h01, 8'hFF, "std bit one");

        // R7 strong pull-up during a slot, R8 idle behaviour
        m_od = 0; m_ll = 0; slave_byte = 8'hFF; sbit = 0; nw = 0;
        wr(2'd3, 8'h0A);
        wr(2'd1, 8'h01);
        wr(2'd0, 8'h02);
        @(negedge dq_oe);
        @(negedge clk);
        chk("R7 spu off while waiting for sample", spu_n, 1);
        repeat (e_smp(0, 0)) @(negedge clk);
        chk("R7 spu on after sample", spu_n, 0);
        wait_flag(0);
        wr(2'd2, 8'h01);
        chk("R8 idle spu off without supply bit", spu_n, 1);
        wr(2'd3, 8'h0C);
        chk("R8 idle spu on with enable and supply", spu_n, 0);
        wr(2'd3, 8'h04);
        chk("R8 supply alone ignored", spu_n, 1);

        // R10 force low gating
        wr(2'd3, 8'h00);
        wr(2'd0, 8'h04);
        chk("R10 force ignored without enable", dq_oe, 0);
        wr(2'd3, 8'h10);
        chk("R10 force drives with enable", dq_oe, 1);
        wr(2'd0, 8'h00);
        chk("R10 force released", dq_oe, 0);
        wr(2'd3, 8'h00);

        // R12 writes while busy are dropped
        begin_xfer(1, 0, 0, 8'h5A, 8'hF0);
        rd(2'd2, d); chk("R11 busy flag during transfer", d[3], 1);
        wr(2'd3, 8'h7E);
        wr(2'd1, 8'h00);
        wr(2'd0, 8'h01);
        end_xfer(1, 0, 0, 8'h5A, 8'hF0, "busy-write");
        rd(2'd3, d); chk("R12 ctrl unchanged", d, 8'h01);
        rd(2'd2, d); chk("R12 no reset ran", d[1], 0);

        // Random transfers, mostly overdrive
        for (int k = 0; k < 12; k++) begin
            bit od = ($urandom % 4) != 0;
            bit ll = $urandom % 2;
            bit bm = ($urandom % 4) == 0;
            logic [7:0] tx = 8'($urandom);
            logic [7:0] sb = 8'($urandom);
            do_xfer(od, ll, bm, tx, sb, "random");
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule